// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is a single DMA channel. It takes its work from a chain of descriptors that sit in memory. Each descriptor is four 32-bit words. For each one, the channel reads the four words and then copies the programmed number of bytes from a source address to a target address. The beat width, the address stepping and the pacing are all set by the descriptor's command word. The channel then follows the link word to the next descriptor. A set stop flag in the link word ends the chain after the current descriptor. A link that points back to an earlier descriptor makes a ring, and the channel runs that ring without any help from software.

Software writes the address of the first descriptor and then sets the run bit. It can clear the run bit to halt the channel part way through. Completion is reported through sticky flags and one interrupt line. The present descriptor, source and target addresses are always visible on output ports, so software can work out how much of a transfer is left.

Descriptor reads and data traffic share one memory port. That port uses a request/acknowledge handshake. Data sits right-justified on the 32-bit buses: byte k of a transfer uses bits 8k+7:8k.

Top module: `dma_desc_chan`

## Requirements
- R1: When run (control bit 31) is written 1 while the channel is idle, the channel reads four words from the descriptor pointer. The words are taken in this order: +0 link, +4 source, +8 target, +12 command. The pointer is written with `reg_sel`=1, and its bits 3:0 always read as zero.
- R2: Command bits 12:0 give the byte count of the descriptor. Bits 15:14 give the beat width: 1 is 1 byte, 2 is 2 bytes, and 3 or 0 is 4 bytes. The last beat shrinks to the bytes that remain, so exactly the programmed count is written. Every request carries 1 to 4 bytes.
- R3: Command bit 31 makes the source address advance by each beat's size, and bit 30 does the same for the target address. When its bit is clear, an address stays fixed.
- R4: Link bits 31:4 give the next descriptor's 16-byte-aligned address. The channel fetches that descriptor next unless link bit 0 is set.
- R5: After a descriptor whose link bit 0 is set, the channel sets stopped (bit 3) and clears run. It issues no more memory requests.
- R6: Command bit 22 sets the start flag (bit 1) when the descriptor begins. Command bit 21 sets the end flag (bit 2) when it completes. Writing 1 to either bit in the control register clears that flag, and either flag drives `irq`.
- R7: The stopped state drives `irq` only while stop interrupt enable (control bit 29) is 1.
- R8: In a ring of descriptors, the channel keeps running and sets the end flag again for every descriptor that completes.
- R9: When command bit 29 (source-paced) or bit 28 (target-paced) is set, the channel waits for `periph_req` high before each burst. A burst is 8 bytes for burst code 1 or 0, 16 bytes for code 2 and 32 bytes for code 3, taken from bits 17:16.
- R10: A descriptor with a byte count of zero completes with no data requests, and its addresses stay as they were loaded.
- R11: Clearing run while a transfer is active halts the channel at the next beat or wait boundary, with stopped set.
- R12: `cur_src` and `cur_tgt` show the live addresses, and `cur_desc` shows the descriptor pointer.
- R13: Once `mem_req` is raised, it stays high with a stable address and direction until `mem_ack`.
- R14: After reset the control readback is zero, `irq` is low and no request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects descriptor pointer |
| reg_wdata | input | 32 | Register write data |
| ctrl_rd | output | 32 | Control/status readback |
| cur_desc | output | 32 | Current descriptor pointer |
| cur_src | output | 32 | Current source address |
| cur_tgt | output | 32 | Current target address |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address |
| mem_nbytes | output | 3 | Bytes in this access (1 to 4) |
| mem_wdata | output | 32 | Right-justified write data |
| mem_ack | input | 1 | Access accepted; read data valid |
| mem_rdata | input | 32 | Right-justified read data |
| periph_req | input | 1 | Peripheral request for paced transfers |
| irq | output | 1 | Interrupt |

## Verification
The bench targets lengths that are not a multiple of the beat width. A design that rounds the length would overwrite the byte just past the buffer, or write too few bytes. A fixed target address is checked so that a design which steps it anyway shows up as a wrong final address and spread-out data. Other cases cover a zero-length descriptor, a burst window in which a channel that ignores pacing would write before the request, and a ring in which a design that stops after one pass would set stopped. Halting with run cleared, and the stop interrupt with its enable off and then on, are checked at the readback and interrupt ports.

// File: rtl/dma_desc_chan.sv
module dma_desc_chan #(
  parameter int LEN_W = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] ctrl_rd,
  output logic [31:0] cur_desc,
  output logic [31:0] cur_src,
  output logic [31:0] cur_tgt,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [2:0]  mem_nbytes,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic        periph_req,
  output logic        irq
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_LOAD, S_WAITQ, S_RD, S_WR, S_DONE} st_t;

  st_t              st;
  logic             run, stop_ien, stopped, end_flag, start_flag;
  logic [27:0]      dptr;
  logic [31:0]      nxt, cmd, dbuf;
  logic [LEN_W-1:0] rem;
  logic [5:0]       bleft;
  logic [1:0]       widx;
  logic [2:0]       wbytes, beat;
  logic [5:0]       bbytes;

  wire inc_s   = cmd[31];
  wire inc_t   = cmd[30];
  wire paced   = cmd[29] | cmd[28];
  wire ctrl_wr = reg_we && !reg_sel;
  wire ptr_wr  = reg_we && reg_sel;
  wire go      = ctrl_wr && reg_wdata[31] && !run;

  always_comb begin
    case (cmd[15:14])
      2'd1:    wbytes = 3'd1;
      2'd2:    wbytes = 3'd2;
      default: wbytes = 3'd4;
    endcase
    case (cmd[17:16])
      2'd2:    bbytes = 6'd16;
      2'd3:    bbytes = 6'd32;
      default: bbytes = 6'd8;
    endcase
    beat = (rem < LEN_W'(wbytes)) ? rem[2:0] : wbytes;
  end

  wire last_beat  = (rem == LEN_W'(beat));
  wire burst_used = (bleft <= {3'b000, beat});

  assign mem_req   = (st == S_FETCH) || (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_wdata = dbuf;
  assign cur_desc  = {dptr, 4'b0000};
  assign irq       = end_flag | start_flag | (stopped & stop_ien);
  assign ctrl_rd   = {run, 1'b0, stop_ien, 25'd0, stopped, end_flag, start_flag, 1'b0};

  always_comb begin
    case (st)
      S_FETCH: begin mem_addr = {dptr, widx, 2'b00}; mem_nbytes = 3'd4; end
      S_RD:    begin mem_addr = cur_src;             mem_nbytes = beat; end
      S_WR:    begin mem_addr = cur_tgt;             mem_nbytes = beat; end
      default: begin mem_addr = 32'd0;               mem_nbytes = 3'd0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      run        <= 1'b0;
      stop_ien   <= 1'b0;
      stopped    <= 1'b0;
      end_flag   <= 1'b0;
      start_flag <= 1'b0;
      dptr       <= '0;
      nxt        <= '0;
      cmd        <= '0;
      dbuf       <= '0;
      rem        <= '0;
      bleft      <= '0;
      widx       <= '0;
      cur_src    <= '0;
      cur_tgt    <= '0;
    end else begin
      if (ctrl_wr) begin
        run      <= reg_wdata[31];
        stop_ien <= reg_wdata[29];
        if (reg_wdata[2]) end_flag   <= 1'b0;
        if (reg_wdata[1]) start_flag <= 1'b0;
        if (go)           stopped    <= 1'b0;
      end
      if (ptr_wr) dptr <= reg_wdata[31:4];

      case (st)
        S_IDLE:
          if (run) begin
            widx <= 2'd0;
            st   <= S_FETCH;
          end
        S_FETCH:
          if (mem_ack) begin
            case (widx)
              2'd0: nxt     <= mem_rdata;
              2'd1: cur_src <= mem_rdata;
              2'd2: cur_tgt <= mem_rdata;
              default: begin
                cmd <= mem_rdata;
                rem <= mem_rdata[LEN_W-1:0];
              end
            endcase
            widx <= widx + 2'd1;
            if (widx == 2'd3) st <= S_LOAD;
          end
        S_LOAD:
          if (!run) begin
            stopped <= 1'b1;
            st      <= S_IDLE;
          end else begin
            if (cmd[22]) start_flag <= 1'b1;
            if (rem == '0)  st <= S_DONE;
            else if (paced) st <= S_WAITQ;
            else            st <= S_RD;
          end
        S_WAITQ:
          if (!run) begin
            stopped <= 1'b1;
            st      <= S_IDLE;
          end else if (periph_req) begin
            bleft <= bbytes;
            st    <= S_RD;
          end
        S_RD:
          if (mem_ack) begin
            dbuf <= mem_rdata;
            st   <= S_WR;
          end
        S_WR:
          if (mem_ack) begin
            if (inc_s) cur_src <= cur_src + 32'(beat);
            if (inc_t) cur_tgt <= cur_tgt + 32'(beat);
            rem   <= rem - LEN_W'(beat);
            bleft <= burst_used ? 6'd0 : bleft - {3'b000, beat};
            if (last_beat) st <= S_DONE;
            else if (!run) begin
              stopped <= 1'b1;
              st      <= S_IDLE;
            end
            else if (paced && burst_used) st <= S_WAITQ;
            else st <= S_RD;
          end
        S_DONE: begin
          if (cmd[21]) end_flag <= 1'b1;
          if (nxt[0]) begin
            run     <= 1'b0;
            stopped <= 1'b1;
            st      <= S_IDLE;
          end else if (!run) begin
            stopped <= 1'b1;
            st      <= S_IDLE;
          end else begin
            dptr <= nxt[31:4];
            widx <= 2'd0;
            st   <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module dma_desc_chan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_ack,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [2:0]  mem_nbytes,
  input logic        stopped,
  input logic [31:0] cur_src,
  input logic [31:0] cur_tgt,
  input logic        inc_s,
  input logic        inc_t,
  input logic        wr_ack,
  input logic [2:0]  beat,
  input logic        load_zero
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R13
  AST_BEAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_nbytes != 3'd0) && (mem_nbytes <= 3'd4)); // R2
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> !mem_req); // R5
  AST_SRC_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack && !inc_s |=> $stable(cur_src)); // R3
  AST_TGT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack && inc_t |=> cur_tgt == $past(cur_tgt) + 32'($past(beat))); // R3
  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    load_zero |=> !mem_req); // R10
endmodule

bind dma_desc_chan dma_desc_chan_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req    (mem_req),
  .mem_ack    (mem_ack),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_nbytes (mem_nbytes),
  .stopped    (stopped),
  .cur_src    (cur_src),
  .cur_tgt    (cur_tgt),
  .inc_s      (inc_s),
  .inc_t      (inc_t),
  .wr_ack     (st == S_WR && mem_ack),
  .beat       (beat),
  .load_zero  (st == S_LOAD && rem == '0)
);

// File: tb/dma_desc_chan_tb.sv
`timescale 1ns/1ps
module dma_desc_chan_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] ctrl_rd, cur_desc, cur_src, cur_tgt;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [2:0]  mem_nbytes;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = 32'd0;
  logic        periph_req = 1'b0;
  logic        irq;

  always #2.5 clk = ~clk;

  dma_desc_chan u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .ctrl_rd(ctrl_rd), .cur_desc(cur_desc), .cur_src(cur_src), .cur_tgt(cur_tgt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_nbytes(mem_nbytes),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .periph_req(periph_req), .irq(irq)
  );

  logic [7:0]  mem [0:1023];
  logic [31:0] rdw;
  int wr_cnt = 0;
  int nvec = 0;
  int nbad = 0;

  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        for (int k = 0; k < 4; k++)
          if (k < int'(mem_nbytes)) mem[10'(mem_addr + 32'(k))] = mem_wdata[8*k +: 8];
        wr_cnt = wr_cnt + 1;
      end else begin
        rdw = 32'd0;
        for (int k = 0; k < 4; k++)
          if (k < int'(mem_nbytes)) rdw[8*k +: 8] = mem[10'(mem_addr + 32'(k))];
        mem_rdata <= rdw;
      end
    end else mem_ack <= 1'b0;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic put_w(input int a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) mem[a + k] = v[8*k +: 8];
  endtask

  task automatic fill(input int a, input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) mem[a + i] = seed + 8'(i);
  endtask

  task automatic desc(input int a, input logic [31:0] nx, input logic [31:0] s,
                      input logic [31:0] t, input logic [31:0] c);
    put_w(a, nx); put_w(a + 4, s); put_w(a + 8, t); put_w(a + 12, c);
  endtask

  task automatic reg_wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic launch(input logic [31:0] dp, input logic [31:0] ctl);
    reg_wr(1'b0, 32'h6);
    reg_wr(1'b1, dp);
    reg_wr(1'b0, ctl);
  endtask

  task automatic wait_stop();
    int n = 0;
    while (!ctrl_rd[3] && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic chk_copy(input string r, input int t, input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) chk(r, {24'd0, mem[t + i]}, {24'd0, seed + 8'(i)});
  endtask

  task automatic t_reset();
    chk("R14 control readback", ctrl_rd, 32'h0);
    chk("R14 irq low", {31'd0, irq}, 32'd0);
    chk("R14 no request", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_basic();
    int w0;
    fill(32'h100, 16, 8'h10);
    desc(32'h40, 32'h1, 32'h100, 32'h200, 32'hC000_0000 | (1 << 21) | (3 << 14) | 16);
    w0 = wr_cnt;
    launch(32'h40, 32'h8000_0000);
    wait_stop();
    chk("R2 word beats", 32'(wr_cnt - w0), 32'd4);
    chk_copy("R13 copy with late acknowledge", 32'h200, 16, 8'h10);
    chk("R6 end flag and R5 stopped", ctrl_rd, 32'h0000_000C);
    chk("R6 irq from end flag", {31'd0, irq}, 32'd1);
    chk("R12 source address", cur_src, 32'h110);
    chk("R12 target address", cur_tgt, 32'h210);
    chk("R1 descriptor pointer", cur_desc, 32'h40);
    chk("R5 no request after stop", {31'd0, mem_req}, 32'd0);
    reg_wr(1'b0, 32'h6);
    chk("R6 flags cleared", ctrl_rd, 32'h0000_0008);
    chk("R7 stop without enable", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_odd();
    int w0;
    for (int i = 0; i < 16; i++) mem[32'h280 + i] = 8'hEE;
    fill(32'h120, 7, 8'h30);
    desc(32'h40, 32'h1, 32'h120, 32'h280, 32'hC000_0000 | (3 << 14) | 7);
    w0 = wr_cnt;
    launch(32'h40, 32'h8000_0000);
    wait_stop();
    chk("R2 short final beat count", 32'(wr_cnt - w0), 32'd2);
    chk_copy("R2 odd length data", 32'h280, 7, 8'h30);
    chk("R2 byte past end untouched", {24'd0, mem[32'h287]}, 32'hEE);
  endtask

  task automatic t_fixed();
    int w0;
    fill(32'h140, 6, 8'h50);
    mem[32'h302] = 8'h00;
    desc(32'h40, 32'h1, 32'h140, 32'h300, 32'h8000_0000 | (2 << 14) | 6);
    w0 = wr_cnt;
    launch(32'h40, 32'h8000_0000);
    wait_stop();
    chk("R2 halfword beats", 32'(wr_cnt - w0), 32'd3);
    chk("R3 target held", cur_tgt, 32'h300);
    chk("R3 source stepped", cur_src, 32'h146);
    chk("R3 last halfword low", {24'd0, mem[32'h300]}, 32'h54);
    chk("R3 last halfword high", {24'd0, mem[32'h301]}, 32'h55);
    chk("R3 no spill", {24'd0, mem[32'h302]}, 32'h00);
  endtask

  task automatic t_bytes();
    int w0;
    fill(32'h160, 5, 8'h70);
    desc(32'h40, 32'h1, 32'h160, 32'h320, 32'hC000_0000 | (1 << 14) | 5);
    w0 = wr_cnt;
    launch(32'h40, 32'h8000_0000);
    wait_stop();
    chk("R2 byte beats", 32'(wr_cnt - w0), 32'd5);
    chk_copy("R2 byte data", 32'h320, 5, 8'h70);
  endtask

  task automatic t_chain();
    int w0;
    fill(32'h180, 16, 8'h90);
    desc(32'h40, 32'h60, 32'h180, 32'h340, 32'hC000_0000 | (3 << 14) | 8);
    desc(32'h60, 32'h1, 32'h188, 32'h348, 32'hC000_0000 | (1 << 21) | (3 << 14) | 8);
    w0 = wr_cnt;
    launch(32'h40, 32'h8000_0000);
    wait_stop();
    chk("R4 beats across chain", 32'(wr_cnt - w0), 32'd4);
    chk_copy("R4 chained data", 32'h340, 16, 8'h90);
    chk("R4 pointer on second", cur_desc, 32'h60);
    chk("R6 end flag only from second", ctrl_rd, 32'h0000_000C);
  endtask

  task automatic t_zero();
    int w0;
    desc(32'h80, 32'h1, 32'h1A0, 32'h360, 32'hC000_0000 | (1 << 22) | (3 << 14));
    w0 = wr_cnt;
    launch(32'h80, 32'h8000_0000);
    wait_stop();
    chk("R10 no data writes", 32'(wr_cnt - w0), 32'd0);
    chk("R10 source unchanged", cur_src, 32'h1A0);
    chk("R6 start flag", ctrl_rd, 32'h0000_000A);
  endtask

  task automatic t_stopirq();
    fill(32'h1B0, 4, 8'hA0);
    desc(32'h80, 32'h1, 32'h1B0, 32'h370, 32'hC000_0000 | (3 << 14) | 4);
    launch(32'h80, 32'hA000_0000);
    wait_stop();
    chk("R7 enable and stopped", ctrl_rd, 32'h2000_0008);
    chk("R7 stop irq", {31'd0, irq}, 32'd1);
    reg_wr(1'b0, 32'h0);
    chk("R7 irq off with enable clear", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_flow();
    int w0;
    fill(32'h1C0, 20, 8'hB0);
    desc(32'h80, 32'h1, 32'h1C0, 32'h380,
         32'hC000_0000 | (1 << 29) | (1 << 16) | (1 << 14) | 20);
    periph_req = 1'b0;
    w0 = wr_cnt;
    launch(32'h80, 32'h8000_0000);
    repeat (60) @(negedge clk);
    chk("R9 no writes without request", 32'(wr_cnt - w0), 32'd0);
    chk("R9 still running", {31'd0, ctrl_rd[31]}, 32'd1);
    periph_req = 1'b1;
    @(negedge clk);
    periph_req = 1'b0;
    repeat (80) @(negedge clk);
    chk("R9 one burst of 8", 32'(wr_cnt - w0), 32'd8);
    periph_req = 1'b1;
    wait_stop();
    periph_req = 1'b0;
    chk("R9 total beats", 32'(wr_cnt - w0), 32'd20);
    chk_copy("R9 paced data", 32'h380, 20, 8'hB0);
  endtask

  task automatic t_halt();
    int w0;
    desc(32'h80, 32'h1, 32'h1C0, 32'h3A0, 32'hC000_0000 | (1 << 28) | (3 << 14) | 16);
    periph_req = 1'b0;
    w0 = wr_cnt;
    launch(32'h80, 32'h8000_0000);
    repeat (30) @(negedge clk);
    reg_wr(1'b0, 32'h0);
    repeat (5) @(negedge clk);
    chk("R11 halted while waiting", ctrl_rd, 32'h0000_0008);
    chk("R11 quiet port", {31'd0, mem_req}, 32'd0);
    chk("R11 nothing written", 32'(wr_cnt - w0), 32'd0);
  endtask

  task automatic t_ring();
    int ev = 0;
    int n = 0;
    fill(32'h100, 8, 8'h10);
    desc(32'h40, 32'h60, 32'h100, 32'h3C0, 32'hC000_0000 | (1 << 21) | (3 << 14) | 4);
    desc(32'h60, 32'h40, 32'h104, 32'h3C4, 32'hC000_0000 | (1 << 21) | (3 << 14) | 4);
    launch(32'h40, 32'h8000_0000);
    while (ev < 6 && n < 3000) begin
      @(negedge clk);
      n++;
      if (ctrl_rd[2]) begin
        ev++;
        reg_wr(1'b0, 32'h8000_0004);
      end
    end
    chk("R8 end events in ring", 32'(ev), 32'd6);
    chk("R8 not stopped", {31'd0, ctrl_rd[3]}, 32'd0);
    chk_copy("R8 ring data", 32'h3C0, 8, 8'h10);
    reg_wr(1'b0, 32'h4);
    wait_stop();
    chk("R11 ring halted", ctrl_rd & 32'h8000_0008, 32'h0000_0008);
    repeat (4) @(negedge clk);
    chk("R11 no request after halt", {31'd0, mem_req}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_odd();
    t_fixed();
    t_bytes();
    t_chain();
    t_zero();
    t_stopirq();
    t_flow();
    t_halt();
    t_ring();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule